// File: doc/BRIEF.md
# Multithreaded Fetch-to-Decode Micro-op Queue

This block buffers micro-ops between an instruction fetch stage and a decode stage that is shared by up to four hardware threads. Each stored entry holds an instruction payload and the 2-bit ID of the thread that fetched it. Fetch offers up to `FW` micro-ops per cycle on packed lanes. Decode removes up to `DW` micro-ops per cycle from the head, in strict arrival order.

Both data sides use valid/ready handshakes. On the write side the queue drives one ready bit per lane. A lane is taken only when its valid and ready are both high. Fetch must present its micro-ops packed from lane 0 upward, because a gap or a predicted-taken branch closes every lane above it. On the read side the back-pressure comes from the per-thread decode-stall vector. An output lane that shows valid is consumed in that same cycle. A lane stays invalid if any entry at or ahead of it belongs to a stalled thread.

A per-thread squash vector deletes all entries of the selected threads in one cycle and keeps the other entries in order. Occupancy, free-slot, full, empty and drained outputs let fetch size its next group of writes.

Top module: `uop_fetch_queue`

## Requirements
- R1: After synchronous reset the queue is empty: occupancy 0, free slots equal to DEPTH (default 32), full low, empty high, drained high, and no output lane valid.
- R2: Write lane j is ready exactly when j is below the registered free-slot count and every lane below j is valid and is not a predicted-taken branch. A lane is accepted when its valid and ready are both high.
- R3: A valid lane whose taken bit is high may itself be accepted. Every lane above it is not ready in that cycle.
- R4: The queue never holds more than DEPTH entries. When it holds DEPTH entries, full is high and all write lanes are not ready.
- R5: Output lane i carries the i-th oldest stored entry (payload and thread ID). An entry accepted at one clock edge can appear on the output lanes from the next cycle on.
- R6: Output lane i (i < DW, default 4) is valid exactly when the queue holds more than i entries, no squash is requested, and none of the entries at positions 0..i belongs to a thread whose bit in the decode-stall vector (bit n = thread n) is high. Valid lanes leave the queue at the next edge.
- R7: A squash cycle removes every stored entry whose thread's bit is set in the squash vector (bit n = thread n). The remaining entries keep their relative order.
- R8: In a squash cycle no output lane is valid. Accepted writes for squashed threads are dropped and take no space. Accepted writes for other threads are stored after the surviving entries.
- R9: Occupancy and free-slot outputs are registered. They reflect the writes, dequeues and squashes of earlier cycles, and free slots equal DEPTH minus occupancy.
- R10: Empty is high when occupancy is 0. Drained is high only when the queue is empty and no write lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | FW | Per-lane write valid, packed from lane 0 |
| in_ready | output | FW | Per-lane write ready |
| in_uop | input | FW*PAY_W | Lane payloads, lane j at bits j*PAY_W |
| in_tid | input | FW*2 | Lane thread IDs, lane j at bits 2*j |
| in_taken | input | FW | Lane holds a predicted-taken branch |
| out_valid | output | DW | Per-lane dequeue valid; valid lanes are consumed |
| out_uop | output | DW*PAY_W | Head payloads, oldest in lane 0 |
| out_tid | output | DW*2 | Head thread IDs |
| dec_stall | input | 4 | Per-thread decode stall |
| squash | input | 4 | Per-thread flush request |
| occupancy | output | CNT_W | Stored entry count |
| free_slots | output | CNT_W | DEPTH minus occupancy |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| drained | output | 1 | Empty and no write lane valid |

## Verification
Lane readiness, output valids and drained follow the inputs combinationally. They are due in the same cycle the stimulus is driven. Occupancy, free slots, full, empty and the contents of the output lanes change one clock edge after the write, dequeue or squash that causes them. The bench drives each cycle's inputs at the falling edge and samples 1 ns later. It compares the combinational results against the model state for that cycle. It advances its reference model only after those checks, so every registered result is compared in the cycle after its cause.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int TID_W = 2;
  localparam int NTHR  = 1 << TID_W;
endpackage

// File: rtl/fq_wr_gate.sv
module fq_wr_gate
  import fq_pkg::*;
#(
  parameter int FW    = 8,
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FW-1:0]       vld,
  input  logic [FW-1:0]       tkn,
  input  logic [FW*TID_W-1:0] tid,
  input  logic [CNT_W-1:0]    free,
  input  logic [NTHR-1:0]     squash,
  output logic [FW-1:0]       rdy,
  output logic [FW-1:0]       keep
);
  logic open;

  always_comb begin
    open = 1'b1;
    for (int j = 0; j < FW; j++) begin
      rdy[j]  = open && (CNT_W'(j) < free);
      keep[j] = vld[j] && rdy[j] && !squash[tid[j*TID_W +: TID_W]];
      open    = open && vld[j] && !tkn[j];
    end
  end

  // R2: never offer more lanes than there are free slots
  a_r2_ready_fits: assert property (@(posedge clk) disable iff (rst)
    CNT_W'($countones(rdy)) <= free);

  // R3: nothing above an offered taken branch is ready
  a_r3_taken_closes: assert property (@(posedge clk) disable iff (rst)
    (vld[0] && tkn[0] && FW > 1) |-> !rdy[FW-1]);
endmodule

// File: rtl/fq_rd_gate.sv
module fq_rd_gate
  import fq_pkg::*;
#(
  parameter int DW    = 4,
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [DW*TID_W-1:0] head_tid,
  input  logic [NTHR-1:0]     stall,
  input  logic [NTHR-1:0]     squash,
  output logic [DW-1:0]       deq
);
  logic go;

  always_comb begin
    go = ~|squash;
    for (int i = 0; i < DW; i++) begin
      go     = go && (CNT_W'(i) < cnt) && !stall[head_tid[i*TID_W +: TID_W]];
      deq[i] = go;
    end
  end

  // R6: the head lane never leaves while its thread is stalled
  a_r6_head_not_stalled: assert property (@(posedge clk) disable iff (rst)
    deq[0] |-> !stall[head_tid[TID_W-1:0]]);

  // R8: a squash cycle holds the read side
  a_r8_squash_holds: assert property (@(posedge clk) disable iff (rst)
    (|squash) |-> (deq == '0));
endmodule

// File: rtl/fq_store.sv
module fq_store
  import fq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int FW    = 8,
  parameter int DW    = 4,
  parameter int PAY_W = 32,
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FW-1:0]       wr_keep,
  input  logic [FW*PAY_W-1:0] wr_pay,
  input  logic [FW*TID_W-1:0] wr_tid,
  input  logic [NTHR-1:0]     squash,
  input  logic [CNT_W-1:0]    n_deq,
  output logic [DW*PAY_W-1:0] head_pay,
  output logic [DW*TID_W-1:0] head_tid,
  output logic [CNT_W-1:0]    count
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [PAY_W-1:0] pay_q [DEPTH];
  logic [PAY_W-1:0] pay_n [DEPTH];
  logic [TID_W-1:0] tid_q [DEPTH];
  logic [TID_W-1:0] tid_n [DEPTH];
  logic [CNT_W-1:0] count_q, pos;

  always_comb begin
    pay_n = pay_q;
    tid_n = tid_q;
    pos   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < count_q) && (CNT_W'(i) >= n_deq) && !squash[tid_q[i]]) begin
        pay_n[pos[IDX_W-1:0]] = pay_q[i];
        tid_n[pos[IDX_W-1:0]] = tid_q[i];
        pos = pos + CNT_W'(1);
      end
    end
    for (int j = 0; j < FW; j++) begin
      if (wr_keep[j] && (pos < DEPTH_C)) begin
        pay_n[pos[IDX_W-1:0]] = wr_pay[j*PAY_W +: PAY_W];
        tid_n[pos[IDX_W-1:0]] = wr_tid[j*TID_W +: TID_W];
        pos = pos + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= pos;
  end

  always_ff @(posedge clk) begin
    pay_q <= pay_n;
    tid_q <= tid_n;
  end

  for (genvar d = 0; d < DW; d++) begin : g_head
    assign head_pay[d*PAY_W +: PAY_W] = pay_q[d];
    assign head_tid[d*TID_W +: TID_W] = tid_q[d];
  end

  assign count = count_q;

  // R4: storage never overfills
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= DEPTH_C);

  logic [NTHR-1:0] sq_prev;
  always_ff @(posedge clk) begin
    if (rst) sq_prev <= '0;
    else     sq_prev <= squash;
  end

  // R7: after a squash no live entry belongs to a squashed thread
  for (genvar e = 0; e < DEPTH; e++) begin : g_sqchk
    a_r7_squash_gone: assert property (@(posedge clk) disable iff (rst)
      (CNT_W'(e) < count_q) |-> !sq_prev[tid_q[e]]);
  end
endmodule

// File: rtl/uop_fetch_queue.sv
module uop_fetch_queue
  import fq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int FW    = 8,
  parameter int DW    = 4,
  parameter int PAY_W = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FW-1:0]       in_valid,
  output logic [FW-1:0]       in_ready,
  input  logic [FW*PAY_W-1:0] in_uop,
  input  logic [FW*TID_W-1:0] in_tid,
  input  logic [FW-1:0]       in_taken,
  output logic [DW-1:0]       out_valid,
  output logic [DW*PAY_W-1:0] out_uop,
  output logic [DW*TID_W-1:0] out_tid,
  input  logic [NTHR-1:0]     dec_stall,
  input  logic [NTHR-1:0]     squash,
  output logic [CNT_W-1:0]    occupancy,
  output logic [CNT_W-1:0]    free_slots,
  output logic                full,
  output logic                empty,
  output logic                drained
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [FW-1:0]    keep;
  logic [CNT_W-1:0] n_deq, n_keep;

  assign free_slots = DEPTH_C - occupancy;
  assign n_deq      = CNT_W'($countones(out_valid));
  assign n_keep     = CNT_W'($countones(keep));

  fq_wr_gate #(.FW(FW), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .vld(in_valid), .tkn(in_taken), .tid(in_tid),
    .free(free_slots), .squash(squash), .rdy(in_ready), .keep(keep)
  );

  fq_rd_gate #(.DW(DW), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .cnt(occupancy), .head_tid(out_tid),
    .stall(dec_stall), .squash(squash), .deq(out_valid)
  );

  fq_store #(.DEPTH(DEPTH), .FW(FW), .DW(DW), .PAY_W(PAY_W), .CNT_W(CNT_W)) u_st (
    .clk(clk), .rst(rst), .wr_keep(keep), .wr_pay(in_uop), .wr_tid(in_tid),
    .squash(squash), .n_deq(n_deq), .head_pay(out_uop), .head_tid(out_tid),
    .count(occupancy)
  );

  assign full    = (occupancy == DEPTH_C);
  assign empty   = (occupancy == '0);
  assign drained = empty && !(|in_valid);

  // R9: without squash, count moves by stored writes minus dequeues
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(|squash)) |->
      occupancy == $past(occupancy) + $past(n_keep) - $past(n_deq));

  // R10: drained implies nothing stored
  a_r10_drained_empty: assert property (@(posedge clk) disable iff (rst)
    drained |-> (empty && occupancy == '0));

  // R4: a full queue offers no write lane
  a_r4_full_blocks: assert property (@(posedge clk) disable iff (rst)
    full |-> (in_ready == '0));
endmodule

// File: tb/uop_fetch_queue_bench.sv
module uop_fetch_queue_bench;
  localparam int DEPTH = 32, FW = 8, DW = 4, PAY_W = 32, TW = 2, NT = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [FW-1:0] b_vld = '0, b_tkn = '0, i_rdy;
  logic [FW-1:0][PAY_W-1:0] b_pay = '0;
  logic [FW-1:0][TW-1:0] b_tid = '0;
  logic [NT-1:0] b_stall = '0, b_sq = '0;
  logic [DW-1:0] o_vld;
  logic [DW-1:0][PAY_W-1:0] o_pay;
  logic [DW-1:0][TW-1:0] o_tid;
  logic [CW-1:0] occ, fre;
  logic full, empty, drained;

  uop_fetch_queue u_uop_fetch_queue (
    .clk(clk), .rst(rst), .in_valid(b_vld), .in_ready(i_rdy), .in_uop(b_pay),
    .in_tid(b_tid), .in_taken(b_tkn), .out_valid(o_vld), .out_uop(o_pay),
    .out_tid(o_tid), .dec_stall(b_stall), .squash(b_sq), .occupancy(occ),
    .free_slots(fre), .full(full), .empty(empty), .drained(drained)
  );

  int errs = 0, checks = 0;
  logic [PAY_W-1:0] m_pay [DEPTH];
  logic [TW-1:0]    m_tid [DEPTH];
  int m_cnt = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [FW-1:0] exp_ready();
    logic open = 1'b1;
    for (int j = 0; j < FW; j++) begin
      exp_ready[j] = open && (j < DEPTH - m_cnt);
      if (!b_vld[j] || b_tkn[j]) open = 1'b0;
    end
  endfunction

  function automatic logic [DW-1:0] exp_out();
    logic go = (b_sq == '0);
    for (int i = 0; i < DW; i++) begin
      go = go && (i < m_cnt) && !b_stall[m_tid[i]];
      exp_out[i] = go;
    end
  endfunction

  // check this cycle's results, then advance the model past the next edge
  task automatic step();
    logic [FW-1:0] er;
    logic [DW-1:0] eo;
    logic [PAY_W-1:0] t_pay [DEPTH];
    logic [TW-1:0] t_tid [DEPTH];
    int n = 0, nd = 0;
    #1;
    er = exp_ready();
    eo = exp_out();
    chk("R9 occupancy", 64'(occ), 64'(m_cnt));
    chk("R9 free", 64'(fre), 64'(DEPTH - m_cnt));
    chk("R4 full", 64'(full), 64'(m_cnt == DEPTH));
    chk("R10 empty", 64'(empty), 64'(m_cnt == 0));
    chk("R10 drained", 64'(drained), 64'(m_cnt == 0 && b_vld == '0));
    chk("R2 ready", 64'(i_rdy), 64'(er));
    chk("R6 out_valid", 64'(o_vld), 64'(eo));
    for (int i = 0; i < DW; i++) if (eo[i]) begin
      chk("R5 payload", 64'(o_pay[i]), 64'(m_pay[i]));
      chk("R5 thread", 64'(o_tid[i]), 64'(m_tid[i]));
      nd++;
    end
    for (int i = 0; i < m_cnt; i++)
      if (i >= nd && !b_sq[m_tid[i]]) begin t_pay[n] = m_pay[i]; t_tid[n] = m_tid[i]; n++; end
    for (int j = 0; j < FW; j++)
      if (b_vld[j] && er[j] && !b_sq[b_tid[j]]) begin t_pay[n] = b_pay[j]; t_tid[n] = b_tid[j]; n++; end
    for (int i = 0; i < n; i++) begin m_pay[i] = t_pay[i]; m_tid[i] = t_tid[i]; end
    m_cnt = n;
    @(negedge clk);
  endtask

  task automatic idle();
    b_vld = '0; b_tkn = '0; b_sq = '0;
  endtask

  task automatic fill_lanes(input logic [FW-1:0] v, input int base);
    b_vld = v; b_tkn = '0;
    for (int j = 0; j < FW; j++) begin
      b_pay[j] = PAY_W'(base + j);
      b_tid[j] = TW'(j % NT);
    end
  endtask

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 occupancy", 64'(occ), 64'd0);
    chk("R1 free", 64'(fre), 64'(DEPTH));
    chk("R1 flags", 64'({full, empty, drained}), 64'b011);
    chk("R1 out_valid", 64'(o_vld), 64'd0);
    @(negedge clk);

    // R4: fill with every thread stalled until full
    b_stall = '1;
    for (int k = 0; k < 5; k++) begin
      fill_lanes('1, 16 * k);
      if (k == 4) begin #1; chk("R4 no ready when full", 64'(i_rdy), 64'd0); end
      step();
    end
    idle();
    // R6: head thread 0 stalled blocks the others
    b_stall = 4'b0001;
    #1; chk("R6 head blocks", 64'(o_vld), 64'd0);
    step();
    b_stall = '0;
    step();
    // R7/R8: squash thread 1 while writing lanes of several threads
    fill_lanes(8'h0F, 200);
    b_sq = 4'b0010;
    #1; chk("R8 no dequeue on squash", 64'(o_vld), 64'd0);
    step();
    idle();
    #1; chk("R7 survivors", 64'(occ), 64'(m_cnt));
    step();
    // drain
    for (int k = 0; k < 20 && m_cnt > 0; k++) step();
    // R3: taken branch in lane 2
    fill_lanes('1, 300);
    b_tkn = 8'b0000_0100;
    #1; chk("R3 taken stops lanes", 64'(i_rdy), 64'h07);
    step();
    // R8: write only squashed thread 3 lanes -> dropped
    for (int k = 0; k < 20 && m_cnt > 0; k++) begin idle(); step(); end
    fill_lanes(8'h08, 400);
    b_sq = 4'b1000;
    step();
    idle();
    #1; chk("R8 dropped write", 64'(occ), 64'd0);
    step();

    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int j = 0; j < FW; j++) begin
        b_vld[j] = ($urandom % 100) < 85;
        b_tkn[j] = ($urandom % 100) < 8;
        b_pay[j] = $urandom;
        b_tid[j] = TW'($urandom);
      end
      for (int t = 0; t < NT; t++) b_stall[t] = ($urandom % 100) < 25;
      b_sq = (($urandom % 100) < 4) ? NT'($urandom) : '0;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule